// File: doc/BRIEF.md
# NAND Byte-to-Halfword Bus Bridge

This block connects a 16-bit host register bus to an 8-bit NAND flash pin interface. The host sees three registers: a data window, a mode register and a status register. The mode register is loaded with fixed command codes. Those codes set the chip-enable, command-latch and address-latch lines, the write-protect release and the media power state.

A host access to the data window becomes one or two NAND byte cycles. A halfword access produces two strobe cycles, low byte first. A byte access produces one. The latch lines stay at the levels the mode register sets, so a byte written in command mode goes out as a command cycle and a byte written in address mode goes out as an address cycle. While the byte cycles run, the host bus is held with a wait signal. Every strobe stays low for a set number of clocks and then high for at least a set number of clocks.

Top module: `nand_halfword_bridge`

## Requirements
- R1: After reset the chip enable is inactive (nandCeN=1), both strobes are high, CLE, ALE, nandWpN and nandPowerEn are 0, and the mode register reads back 0x00.
- R2: Writing mode byte 0x94 enables the chip with both latches low. Writing 0x95 also raises CLE, writing 0x96 also raises ALE, and writing 0x00 deselects the chip. Chip enable is mode bit 4 (active high in the register), ALE is bit 1 and CLE is bit 0.
- R3: A mode write with bit 3 set loads media power from bit 2, so 0x0C turns power on and 0x08 turns it off. A mode write with bit 3 clear, such as 0x94, leaves power unchanged.
- R4: A read at offset 5 returns 0x0080 while nandRdy is low (busy) and 0x0000 while it is high.
- R5: A halfword write at offset 0 drives two write-strobe cycles on nandIo: bits 7:0 first, then bits 15:8.
- R6: A halfword read at offset 0 runs two read-strobe cycles. The first byte returned lands in bits 7:0 and the second in bits 15:8. A byte read returns its byte in bits 7:0 with bits 15:8 zero.
- R7: A byte write at offset 0 in command or address mode emits exactly one write-strobe cycle, with CLE or ALE high to match the mode.
- R8: Each strobe stays low for exactly LOW_CYCLES clocks and then high for at least HIGH_CYCLES clocks before the next strobe falls.
- R9: hostWait is held for 2*(LOW_CYCLES+HIGH_CYCLES)+1 clocks on a halfword data access and LOW_CYCLES+HIGH_CYCLES+1 clocks on a byte data access. It is released only after all of that access's byte cycles have finished.
- R10: Accesses at offsets 4 and 5 complete without asserting hostWait and cause no NAND strobe.
- R11: Mode bit 7 drives nandWpN, and a read at offset 4 returns the mode byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostSel | input | 1 | Host access request, held until the cycle hostWait is low |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostHalf | input | 1 | 1 = halfword data access, 0 = byte |
| hostAddr | input | 3 | Register offset: 0 data, 4 mode, 5 status |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Host read data, valid when hostWait is low |
| hostWait | output | 1 | Stalls the host while NAND byte cycles run |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandWpN | output | 1 | Write-protect release (mode bit 7) |
| nandPowerEn | output | 1 | Media power enable |
| nandRdy | input | 1 | Ready/busy line, low = busy |
| nandIo | inout | 8 | NAND data bus |

## Verification
The bench drives byte writes in command mode and in address mode to confirm that the latch lines follow the mode register on the single cycle each one emits. Halfword writes and reads use asymmetric byte values (0xBEEF, and stub bytes 0x3C then 0xA5), so a swapped byte order or a missing second cycle shows up as a wrong value. A byte read after a halfword read would expose stale upper bits. Power codes are interleaved with the data-mode code, which separates a real power latch from one that copies bit 2 on every write.

// File: rtl/nand_bridge_pkg.sv
package nand_bridge_pkg;

  localparam logic [2:0] ADDR_DATA = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd4;
  localparam logic [2:0] ADDR_STAT = 3'd5;

  localparam int MB_WPREL = 7;
  localparam int MB_CE    = 4;
  localparam int MB_PLOAD = 3;
  localparam int MB_PVAL  = 2;
  localparam int MB_ALE   = 1;
  localparam int MB_CLE   = 0;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LOW,
    SEQ_HIGH,
    SEQ_DONE
  } seqState_t;

  typedef struct packed {
    logic start;
    logic weLow;
    logic reLow;
    logic ioOe;
    logic hiByte;
    logic capture;
  } bridgeCtl_t;

endpackage

// File: rtl/nand_bridge_ctrl.sv
module nand_bridge_ctrl
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYCLES  = 2,
  parameter int HIGH_CYCLES = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWrite,
  input  logic       hostHalf,
  input  logic [2:0] hostAddr,
  output bridgeCtl_t ctl,
  output logic       hostWait
);

  localparam int MAX_CNT = (LOW_CYCLES > HIGH_CYCLES) ? LOW_CYCLES : HIGH_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CNT + 1);
  localparam logic [CNT_W-1:0] LOW_LAST  = CNT_W'(LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_CYCLES - 1);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             secondByte;
  logic             isWrite;
  logic             isHalf;
  logic             dataReq;

  assign dataReq = hostSel && (hostAddr == ADDR_DATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= SEQ_IDLE;
      cnt        <= '0;
      secondByte <= 1'b0;
      isWrite    <= 1'b0;
      isHalf     <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (dataReq) begin
            state      <= SEQ_LOW;
            cnt        <= '0;
            secondByte <= 1'b0;
            isWrite    <= hostWrite;
            isHalf     <= hostHalf;
          end
        end
        SEQ_LOW: begin
          if (cnt == LOW_LAST) begin
            state <= SEQ_HIGH;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SEQ_HIGH: begin
          if (cnt == HIGH_LAST) begin
            cnt <= '0;
            if (isHalf && !secondByte) begin
              secondByte <= 1'b1;
              state      <= SEQ_LOW;
            end else begin
              state <= SEQ_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.start   = (state == SEQ_IDLE) && dataReq;
    ctl.weLow   = (state == SEQ_LOW) && isWrite;
    ctl.reLow   = (state == SEQ_LOW) && !isWrite;
    ctl.ioOe    = isWrite && ((state == SEQ_LOW) || (state == SEQ_HIGH));
    ctl.hiByte  = secondByte;
    ctl.capture = (state == SEQ_LOW) && !isWrite && (cnt == LOW_LAST);
    hostWait    = dataReq && (state != SEQ_DONE);
  end

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.weLow && ctl.reLow));

  // R9
  second_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == SEQ_DONE) && isHalf |-> secondByte);

endmodule

// File: rtl/nand_bridge_dp.sv
module nand_bridge_dp
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYCLES  = 2,
  parameter int HIGH_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  bridgeCtl_t  ctl,
  input  logic        hostSel,
  input  logic        hostWrite,
  input  logic [2:0]  hostAddr,
  input  logic [15:0] hostWdata,
  input  logic        nandRdy,
  input  logic [7:0]  ioIn,
  output logic [15:0] hostRdata,
  output logic [7:0]  ioOut,
  output logic        ioOe,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic        nandWpN,
  output logic        nandPowerEn
);

  localparam int RUN_W = $clog2(LOW_CYCLES + HIGH_CYCLES + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [7:0]  modeReg;
  logic        powerReg;
  logic [15:0] wrData;
  logic [15:0] rdData;
  logic        modeWr;

  assign modeWr = hostSel && hostWrite && (hostAddr == ADDR_MODE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      powerReg <= 1'b0;
    end else if (modeWr) begin
      modeReg <= hostWdata[7:0];
      if (hostWdata[MB_PLOAD]) powerReg <= hostWdata[MB_PVAL];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrData <= '0;
      rdData <= '0;
    end else begin
      if (ctl.start) begin
        wrData <= hostWdata;
        rdData <= '0;
      end
      if (ctl.capture) begin
        if (ctl.hiByte) rdData[15:8] <= ioIn;
        else            rdData[7:0]  <= ioIn;
      end
    end
  end

  always_comb begin
    case (hostAddr)
      ADDR_MODE: hostRdata = {8'h00, modeReg};
      ADDR_STAT: hostRdata = {8'h00, !nandRdy, 7'b0};
      ADDR_DATA: hostRdata = rdData;
      default:   hostRdata = '0;
    endcase
  end

  assign ioOut       = ctl.hiByte ? wrData[15:8] : wrData[7:0];
  assign ioOe        = ctl.ioOe;
  assign nandWeN     = !ctl.weLow;
  assign nandReN     = !ctl.reLow;
  assign nandCeN     = !modeReg[MB_CE];
  assign nandCle     = modeReg[MB_CLE];
  assign nandAle     = modeReg[MB_ALE];
  assign nandWpN     = modeReg[MB_WPREL];
  assign nandPowerEn = powerReg;

  // Pin-level run counters for strobe width checking
  logic             anyLow;
  logic [RUN_W-1:0] lowRun;
  logic [RUN_W-1:0] highRun;

  assign anyLow = !nandWeN || !nandReN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= RUN_W'(HIGH_CYCLES);
    end else if (anyLow) begin
      lowRun  <= (lowRun == RUN_MAX) ? lowRun : lowRun + 1'b1;
      highRun <= '0;
    end else begin
      lowRun  <= '0;
      highRun <= (highRun == RUN_MAX) ? highRun : highRun + 1'b1;
    end
  end

  // R8
  strobe_low_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(anyLow) |-> (lowRun == RUN_W'(LOW_CYCLES)));

  // R8
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(anyLow) |-> (highRun >= RUN_W'(HIGH_CYCLES)));

  // R6
  no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !ioOe);

endmodule

// File: rtl/nand_halfword_bridge.sv
module nand_halfword_bridge
  import nand_bridge_pkg::*;
#(
  parameter int LOW_CYCLES  = 2,
  parameter int HIGH_CYCLES = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostSel,
  input  logic        hostWrite,
  input  logic        hostHalf,
  input  logic [2:0]  hostAddr,
  input  logic [15:0] hostWdata,
  output logic [15:0] hostRdata,
  output logic        hostWait,
  output logic        nandCeN,
  output logic        nandCle,
  output logic        nandAle,
  output logic        nandWeN,
  output logic        nandReN,
  output logic        nandWpN,
  output logic        nandPowerEn,
  input  logic        nandRdy,
  inout  wire  [7:0]  nandIo
);

  bridgeCtl_t ctl;
  logic [7:0] ioOut;
  logic       ioOe;

  nand_bridge_ctrl #(
    .LOW_CYCLES (LOW_CYCLES),
    .HIGH_CYCLES(HIGH_CYCLES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostSel  (hostSel),
    .hostWrite(hostWrite),
    .hostHalf (hostHalf),
    .hostAddr (hostAddr),
    .ctl      (ctl),
    .hostWait (hostWait)
  );

  nand_bridge_dp #(
    .LOW_CYCLES (LOW_CYCLES),
    .HIGH_CYCLES(HIGH_CYCLES)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .hostSel    (hostSel),
    .hostWrite  (hostWrite),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .nandRdy    (nandRdy),
    .ioIn       (nandIo),
    .hostRdata  (hostRdata),
    .ioOut      (ioOut),
    .ioOe       (ioOe),
    .nandCeN    (nandCeN),
    .nandCle    (nandCle),
    .nandAle    (nandAle),
    .nandWeN    (nandWeN),
    .nandReN    (nandReN),
    .nandWpN    (nandWpN),
    .nandPowerEn(nandPowerEn)
  );

  assign nandIo = ioOe ? ioOut : 8'hzz;

  // Count strobe rising edges within one data access
  logic       strobeLow;
  logic       prevStrobeLow;
  logic [1:0] strobeRises;
  logic       dataDone;

  assign strobeLow = !nandWeN || !nandReN;
  assign dataDone  = hostSel && (hostAddr == ADDR_DATA) && !hostWait;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevStrobeLow <= 1'b0;
      strobeRises   <= '0;
    end else begin
      prevStrobeLow <= strobeLow;
      if (dataDone) strobeRises <= '0;
      else if (prevStrobeLow && !strobeLow) strobeRises <= strobeRises + 1'b1;
    end
  end

  // R9
  wait_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataDone |-> (strobeRises == (hostHalf ? 2'd2 : 2'd1)));

  // R10
  reg_nowait_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostSel && (hostAddr != ADDR_DATA) |-> !hostWait && !strobeLow);

  // R4
  busy_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostSel && !hostWrite && (hostAddr == ADDR_STAT) |-> (hostRdata[7] == !nandRdy));

endmodule

// File: tb/test_nand_halfword_bridge.sv
`timescale 1ns/1ps
module test_nand_halfword_bridge;

  localparam int LOWC  = 2;
  localparam int HIGHC = 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostSel = 1'b0;
  logic        hostWrite = 1'b0;
  logic        hostHalf = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        hostWait;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandWpN, nandPowerEn;
  logic        nandRdy = 1'b1;
  wire  [7:0]  nandIo;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nand_halfword_bridge #(.LOW_CYCLES(LOWC), .HIGH_CYCLES(HIGHC)) i_nand_halfword_bridge (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite), .hostHalf(hostHalf),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata), .hostWait(hostWait),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN),
    .nandReN(nandReN), .nandWpN(nandWpN), .nandPowerEn(nandPowerEn), .nandRdy(nandRdy),
    .nandIo(nandIo)
  );

  // NAND stub: returns successive bytes on read strobes
  logic [7:0] stubBytes [4] = '{8'h3C, 8'hA5, 8'h5A, 8'h77};
  int stubIdx = 0;
  assign nandIo = !nandReN ? stubBytes[stubIdx] : 8'hzz;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Reference model of mode-driven pins, compared every clock
  logic [7:0] expMode = 8'h00;
  bit         expPower = 1'b0;
  bit         modelOn = 0;

  // Monitor of NAND byte cycles
  int wrBytes[$], wrCle[$], wrAle[$], wrLow[$], rdLow[$];
  int lowCnt = 0, highCnt = 100, minGap = 100;
  bit prevWeLow = 0, prevReLow = 0;
  logic [7:0] curByte;
  bit curCle, curAle;

  always @(negedge clk) begin
    if (modelOn) begin
      check(nandCeN == !expMode[4], "R2 ceN", nandCeN, !expMode[4]);
      check(nandCle == expMode[0] && nandAle == expMode[1], "R2 cle/ale",
            {nandCle, nandAle}, {expMode[0], expMode[1]});
      check(nandWpN == expMode[7], "R11 wpN", nandWpN, expMode[7]);
      check(nandPowerEn == expPower, "R3 power", nandPowerEn, expPower);
    end
    if (!nandWeN || !nandReN) begin
      if (!prevWeLow && !prevReLow && highCnt < minGap) minGap = highCnt;
      lowCnt++;
      highCnt = 0;
      if (!nandWeN) begin curByte = nandIo; curCle = nandCle; curAle = nandAle; end
    end else begin
      if (prevWeLow) begin
        wrBytes.push_back(curByte); wrCle.push_back(curCle);
        wrAle.push_back(curAle); wrLow.push_back(lowCnt);
      end
      if (prevReLow) begin
        rdLow.push_back(lowCnt);
        stubIdx = stubIdx + 1;
      end
      lowCnt = 0;
      highCnt++;
    end
    prevWeLow = !nandWeN;
    prevReLow = !nandReN;
  end

  task automatic access(input bit wr, input bit half, input logic [2:0] addr,
                        input logic [15:0] wd, output logic [15:0] rd, output int waits);
    @(negedge clk);
    hostSel = 1'b1; hostWrite = wr; hostHalf = half; hostAddr = addr; hostWdata = wd;
    waits = 0;
    forever begin
      #1;
      if (!hostWait) break;
      waits++;
      @(negedge clk);
    end
    rd = hostRdata;
    @(posedge clk);
    if (wr && addr == 3'd4) begin
      expMode = wd[7:0];
      if (wd[3]) expPower = wd[2];
    end
    #1;
    hostSel = 1'b0; hostWrite = 1'b0; hostHalf = 1'b0;
  endtask

  task automatic clearMon();
    wrBytes.delete(); wrCle.delete(); wrAle.delete(); wrLow.delete(); rdLow.delete();
    minGap = 100;
  endtask

  initial begin
    logic [15:0] rd;
    int waits;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(nandCeN && nandWeN && nandReN, "R1 strobes/ce", {nandCeN, nandWeN, nandReN}, 3'b111);
    check(!nandCle && !nandAle && !nandWpN && !nandPowerEn, "R1 latches/power",
          {nandCle, nandAle, nandWpN, nandPowerEn}, 0);
    rstN = 1'b1;
    modelOn = 1;
    access(0, 0, 3'd4, 16'h0, rd, waits);
    check(rd == 16'h0000, "R1 mode readback", rd, 0);

    // R3 power on, then command mode
    access(1, 0, 3'd4, 16'h000C, rd, waits);
    check(waits == 0, "R10 mode write wait", waits, 0);
    access(1, 0, 3'd4, 16'h0095, rd, waits);
    check(nandPowerEn == 1'b1, "R3 0x95 keeps power", nandPowerEn, 1);
    clearMon();
    access(1, 0, 3'd0, 16'h1270, rd, waits);
    @(negedge clk);
    check(wrBytes.size() == 1, "R7 one command cycle", wrBytes.size(), 1);
    if (wrBytes.size() >= 1) begin
      check(wrBytes[0] == 8'h70, "R7 command byte", wrBytes[0], 8'h70);
      check(wrCle[0] == 1 && wrAle[0] == 0, "R7 cle in command", {wrCle[0], wrAle[0]}, 2'b10);
      check(wrLow[0] == LOWC, "R8 low width", wrLow[0], LOWC);
    end
    check(waits == LOWC + HIGHC + 1, "R9 byte wait", waits, LOWC + HIGHC + 1);

    // Address mode
    access(1, 0, 3'd4, 16'h0096, rd, waits);
    clearMon();
    access(1, 0, 3'd0, 16'h0021, rd, waits);
    @(negedge clk);
    check(wrBytes.size() == 1, "R7 one address cycle", wrBytes.size(), 1);
    if (wrBytes.size() >= 1) begin
      check(wrBytes[0] == 8'h21, "R7 address byte", wrBytes[0], 8'h21);
      check(wrCle[0] == 0 && wrAle[0] == 1, "R7 ale in address", {wrCle[0], wrAle[0]}, 2'b01);
    end

    // Data mode halfword write
    access(1, 0, 3'd4, 16'h0094, rd, waits);
    clearMon();
    access(1, 1, 3'd0, 16'hBEEF, rd, waits);
    @(negedge clk);
    check(wrBytes.size() == 2, "R5 two cycles", wrBytes.size(), 2);
    if (wrBytes.size() >= 2) begin
      check(wrBytes[0] == 8'hEF, "R5 first byte low", wrBytes[0], 8'hEF);
      check(wrBytes[1] == 8'hBE, "R5 second byte high", wrBytes[1], 8'hBE);
      check(wrLow[1] == LOWC, "R8 second low width", wrLow[1], LOWC);
      check(wrCle[0] == 0 && wrAle[0] == 0, "R2 data latches", {wrCle[0], wrAle[0]}, 0);
    end
    check(minGap >= HIGHC, "R8 high gap", minGap, HIGHC);
    check(waits == 2 * (LOWC + HIGHC) + 1, "R9 halfword wait", waits, 2 * (LOWC + HIGHC) + 1);

    // Halfword read
    clearMon();
    access(0, 1, 3'd0, 16'h0, rd, waits);
    check(rd == 16'hA53C, "R6 halfword read order", rd, 16'hA53C);
    @(negedge clk);
    check(rdLow.size() == 2, "R6 two read cycles", rdLow.size(), 2);
    check(waits == 2 * (LOWC + HIGHC) + 1, "R9 read wait", waits, 2 * (LOWC + HIGHC) + 1);
    // Byte read
    access(0, 0, 3'd0, 16'h0, rd, waits);
    check(rd == 16'h005A, "R6 byte read", rd, 16'h005A);

    // Status
    nandRdy = 1'b0;
    clearMon();
    access(0, 0, 3'd5, 16'h0, rd, waits);
    check(rd == 16'h0080, "R4 busy", rd, 16'h0080);
    check(waits == 0, "R10 status no wait", waits, 0);
    @(negedge clk);
    check(wrBytes.size() == 0 && rdLow.size() == 0, "R10 no strobe", rdLow.size(), 0);
    nandRdy = 1'b1;
    access(0, 0, 3'd5, 16'h0, rd, waits);
    check(rd == 16'h0000, "R4 ready", rd, 0);

    // Mode readback and power sequencing
    access(0, 0, 3'd4, 16'h0, rd, waits);
    check(rd == 16'h0094, "R11 mode readback", rd, 16'h0094);
    access(1, 0, 3'd4, 16'h0008, rd, waits);
    access(1, 0, 3'd4, 16'h0094, rd, waits);
    @(negedge clk);
    check(nandPowerEn == 1'b0, "R3 power stays off", nandPowerEn, 0);
    access(1, 0, 3'd4, 16'h0090, rd, waits);
    @(negedge clk);
    check(nandWpN == 1'b1, "R11 wp release", nandWpN, 1);
    access(1, 0, 3'd4, 16'h0000, rd, waits);
    @(negedge clk);
    check(nandCeN == 1'b1, "R2 standby", nandCeN, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule